// File: doc/BRIEF.md
# Register Status Rename Table

This block keeps one status record per architectural register for an out-of-order core that retires in program order. Each record holds the last retired value of the register, a pending flag and the tag of the reorder-buffer slot that will produce the register's next value. The issue stage uses the table to resolve two source operands. A source that is not pending returns its value. A pending source returns the producer tag, which the caller then looks up in the reorder buffer. The same issue then claims the destination register for the slot it has just allocated.

At retirement the table takes the retired value. The register stops pending only if its record still names the retiring slot. If a younger instruction has renamed the register since, that younger claim stays in place. A misprediction flush drops every pending claim at once. Register 0 is hardwired: it never pends and always reads zero. Tag value 0 is reserved and means "ready, no producer". Valid slot tags run from 1 to 2^TAG_W-1.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register is not pending and holds value 0, so both lookups return data 0 with tag 0.
- R2: A lookup of a register that is not pending returns its stored value with tag 0. The lookup is combinational on the current state.
- R3: With `alloc_en` high, the register `alloc_reg` becomes pending with tag `alloc_tag` from the next cycle. A lookup in the same cycle still sees the state before the claim.
- R4: With `retire_en` high, `retire_data` is written into the value of `retire_reg`, and lookups see it from the next cycle.
- R5: A retirement clears the pending flag only when the stored tag equals `retire_tag`. Otherwise the pending flag and tag stay unchanged.
- R6: When an allocation and a retirement target the same register in one cycle, the allocation's pending flag and tag win.
- R7: `flush` clears every pending flag and tag from the next cycle. An allocation in the same cycle is discarded. A retirement value in the same cycle is still written.
- R8: Register 0 is never pending, ignores retirement writes and always reads data 0 with tag 0.
- R9: A lookup of a nonzero register that is being retired in the same cycle returns `retire_data` with tag 0, provided the register is not pending or its tag equals `retire_tag`. If it is pending on a different tag, that tag is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_en | input | 1 | Claim the destination register at issue |
| alloc_reg | input | REG_W | Destination register index |
| alloc_tag | input | TAG_W | Newly allocated reorder slot (nonzero) |
| retire_en | input | 1 | Retire one result |
| retire_reg | input | REG_W | Destination register of the retiring slot |
| retire_tag | input | TAG_W | Tag of the retiring slot |
| retire_data | input | DATA_W | Retired result value |
| flush | input | 1 | Misprediction: drop all pending claims |
| srca_reg | input | REG_W | First source register index |
| srca_data | output | DATA_W | First source value (valid when tag is 0) |
| srca_tag | output | TAG_W | First source producer tag, 0 if ready |
| srcb_reg | input | REG_W | Second source register index |
| srcb_data | output | DATA_W | Second source value (valid when tag is 0) |
| srcb_tag | output | TAG_W | Second source producer tag, 0 if ready |

## Verification
The bench builds the table with 8 registers, 3-bit tags and 16-bit data. With so few registers and tags, random traffic often renames a register that is already pending. It also often retires a slot whose tag either matches or has gone stale, and often retires a register in the same cycle it is looked up or claimed. Directed steps first pin down the reset state, stale-tag retirement, rename-over-retire priority, register 0 and flush with concurrent allocation and retirement. A long random run then adds flushes at a low rate.

// File: rtl/regstat_pkg.sv
package regstat_pkg;

  // Where a source lookup takes its answer from
  typedef enum logic [1:0] {
    LK_FILE    = 2'd0,
    LK_BYPASS  = 2'd1,
    LK_PENDING = 2'd2
  } lookup_src_e;

endpackage

// File: rtl/regstat_entry.sv
module regstat_entry #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_hit,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              ret_hit,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic [DATA_W-1:0] ret_data,
  input  logic              flush,
  output logic              busy_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);

  logic              busy_q, busy_nx;
  logic [TAG_W-1:0]  tag_q, tag_nx;
  logic [DATA_W-1:0] data_q;
  logic              stat_en;

  assign stat_en = flush | iss_hit | ret_hit;

  always_comb begin
    busy_nx = busy_q;
    tag_nx  = tag_q;
    if (flush) begin
      busy_nx = 1'b0;
      tag_nx  = '0;
    end else if (iss_hit) begin
      busy_nx = 1'b1;
      tag_nx  = iss_tag;
    end else if (ret_hit && busy_q && (tag_q == ret_tag)) begin
      busy_nx = 1'b0;
      tag_nx  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      if (stat_en) begin
        busy_q <= busy_nx;
        tag_q  <= tag_nx;
      end
      if (ret_hit) begin
        data_q <= ret_data;
      end
    end
  end

  assign busy_o = busy_q;
  assign tag_o  = tag_q;
  assign data_o = data_q;

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!busy_q && tag_q == '0));

  // R3
  issue_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_hit && !flush) |=> (busy_q && tag_q == $past(iss_tag)));

  // R5
  stale_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_hit && !iss_hit && !flush && busy_q && tag_q != ret_tag)
      |=> (busy_q && tag_q == $past(tag_q)));

  // R5
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_hit && !iss_hit && !flush && busy_q && tag_q == ret_tag) |=> !busy_q);

  // R4
  retire_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_hit |=> (data_q == $past(ret_data)));

endmodule

// File: rtl/regstat_lookup.sv
module regstat_lookup
  import regstat_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int REG_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  idx,
  input  logic              busy_arr [NREGS],
  input  logic [TAG_W-1:0]  tag_arr  [NREGS],
  input  logic [DATA_W-1:0] data_arr [NREGS],
  input  logic              ret_en,
  input  logic [REG_W-1:0]  ret_reg,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic [DATA_W-1:0] ret_data,
  output logic [DATA_W-1:0] data_o,
  output logic [TAG_W-1:0]  tag_o
);

  logic              sel_busy;
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_data;
  logic              ret_same;
  lookup_src_e       src;

  assign sel_busy = busy_arr[idx];
  assign sel_tag  = tag_arr[idx];
  assign sel_data = data_arr[idx];
  assign ret_same = ret_en && (ret_reg == idx) && (idx != '0);

  always_comb begin
    src = LK_FILE;
    if (ret_same && (!sel_busy || sel_tag == ret_tag)) begin
      src = LK_BYPASS;
    end else if (sel_busy) begin
      src = LK_PENDING;
    end
  end

  assign data_o = (src == LK_BYPASS)  ? ret_data : sel_data;
  assign tag_o  = (src == LK_PENDING) ? sel_tag  : '0;

  // R9
  bypass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_same && !sel_busy) |-> (data_o == ret_data && tag_o == '0));

  // R2
  ready_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_busy) |-> (tag_o == '0));

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NREGS  = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int REG_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              retire_en,
  input  logic [REG_W-1:0]  retire_reg,
  input  logic [TAG_W-1:0]  retire_tag,
  input  logic [DATA_W-1:0] retire_data,
  input  logic              flush,
  input  logic [REG_W-1:0]  srca_reg,
  output logic [DATA_W-1:0] srca_data,
  output logic [TAG_W-1:0]  srca_tag,
  input  logic [REG_W-1:0]  srcb_reg,
  output logic [DATA_W-1:0] srcb_data,
  output logic [TAG_W-1:0]  srcb_tag
);

  localparam int NPORTS = 2;

  logic              busy_arr [NREGS];
  logic [TAG_W-1:0]  tag_arr  [NREGS];
  logic [DATA_W-1:0] data_arr [NREGS];

  logic [REG_W-1:0]  lk_idx  [NPORTS];
  logic [DATA_W-1:0] lk_data [NPORTS];
  logic [TAG_W-1:0]  lk_tag  [NPORTS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic iss_hit, ret_hit;
    if (g == 0) begin : g_zero
      assign iss_hit = 1'b0;
      assign ret_hit = 1'b0;
    end else begin : g_live
      assign iss_hit = alloc_en  && (alloc_reg  == REG_W'(g));
      assign ret_hit = retire_en && (retire_reg == REG_W'(g));
    end

    regstat_entry #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W)
    ) i_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .iss_hit  (iss_hit),
      .iss_tag  (alloc_tag),
      .ret_hit  (ret_hit),
      .ret_tag  (retire_tag),
      .ret_data (retire_data),
      .flush    (flush),
      .busy_o   (busy_arr[g]),
      .tag_o    (tag_arr[g]),
      .data_o   (data_arr[g])
    );
  end

  assign lk_idx[0] = srca_reg;
  assign lk_idx[1] = srcb_reg;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    regstat_lookup #(
      .NREGS  (NREGS),
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W)
    ) i_lookup (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (lk_idx[p]),
      .busy_arr (busy_arr),
      .tag_arr  (tag_arr),
      .data_arr (data_arr),
      .ret_en   (retire_en),
      .ret_reg  (retire_reg),
      .ret_tag  (retire_tag),
      .ret_data (retire_data),
      .data_o   (lk_data[p]),
      .tag_o    (lk_tag[p])
    );
  end

  assign srca_data = lk_data[0];
  assign srca_tag  = lk_tag[0];
  assign srcb_data = lk_data[1];
  assign srcb_tag  = lk_tag[1];

  // R8
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_arr[0] && data_arr[0] == '0));

endmodule

// File: tb/test_rename_status_table.sv
`timescale 1ns/1ps
module test_rename_status_table;

  localparam int NREGS  = 8;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 3;
  localparam int REG_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_en, retire_en, flush;
  logic [REG_W-1:0]  alloc_reg, retire_reg, srca_reg, srcb_reg;
  logic [TAG_W-1:0]  alloc_tag, retire_tag;
  logic [DATA_W-1:0] retire_data;
  logic [DATA_W-1:0] srca_data, srcb_data;
  logic [TAG_W-1:0]  srca_tag, srcb_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] m_val  [NREGS];
  bit                m_busy [NREGS];
  logic [TAG_W-1:0]  m_tag  [NREGS];

  always #2.5 clk = ~clk;

  rename_status_table #(
    .NREGS  (NREGS),
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W)
  ) i_rename_status_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (alloc_en),
    .alloc_reg   (alloc_reg),
    .alloc_tag   (alloc_tag),
    .retire_en   (retire_en),
    .retire_reg  (retire_reg),
    .retire_tag  (retire_tag),
    .retire_data (retire_data),
    .flush       (flush),
    .srca_reg    (srca_reg),
    .srca_data   (srca_data),
    .srca_tag    (srca_tag),
    .srcb_reg    (srcb_reg),
    .srcb_data   (srcb_data),
    .srcb_tag    (srcb_tag)
  );

  task automatic check_port(string req, string name, int r,
                            logic [DATA_W-1:0] act_d, logic [TAG_W-1:0] act_t);
    logic [DATA_W-1:0] exp_d;
    logic [TAG_W-1:0]  exp_t;
    string lbl;
    bit fwd;
    fwd = retire_en && (int'(retire_reg) == r) && (r != 0) &&
          (!m_busy[r] || m_tag[r] == retire_tag);
    if (fwd) begin
      exp_d = retire_data; exp_t = '0;
    end else begin
      exp_d = m_val[r]; exp_t = m_busy[r] ? m_tag[r] : '0;
    end
    lbl = req;
    if (lbl == "") lbl = fwd ? "R9" : (m_busy[r] ? "R3" : "R2");
    checks++;
    if (act_d !== exp_d || act_t !== exp_t) begin
      errors++;
      $display("FAIL %s port %s reg %0d: data %h tag %0d, expected data %h tag %0d",
               lbl, name, r, act_d, act_t, exp_d, exp_t);
    end
  endtask

  task automatic step(string req, bit ae, int ar, int at, bit re, int rr, int rt,
                      int rd, bit fl, int sa, int sb);
    @(negedge clk);
    alloc_en = ae;  alloc_reg = REG_W'(ar);  alloc_tag = TAG_W'(at);
    retire_en = re; retire_reg = REG_W'(rr); retire_tag = TAG_W'(rt);
    retire_data = DATA_W'(rd); flush = fl;
    srca_reg = REG_W'(sa); srcb_reg = REG_W'(sb);
    #1;
    check_port(req, "a", sa, srca_data, srca_tag);
    check_port(req, "b", sb, srcb_data, srcb_tag);
    @(posedge clk);
    if (re && rr != 0) m_val[rr] = DATA_W'(rd);
    if (fl) begin
      for (int i = 0; i < NREGS; i++) begin m_busy[i] = 0; m_tag[i] = '0; end
    end else begin
      if (re && rr != 0 && m_busy[rr] && m_tag[rr] == TAG_W'(rt)) begin
        m_busy[rr] = 0; m_tag[rr] = '0;
      end
      if (ae && ar != 0) begin m_busy[ar] = 1; m_tag[ar] = TAG_W'(at); end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): run incomplete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREGS; i++) begin m_val[i] = '0; m_busy[i] = 0; m_tag[i] = '0; end
    rst_n = 1'b0;
    alloc_en = 0; retire_en = 0; flush = 0;
    alloc_reg = '0; alloc_tag = '0; retire_reg = '0; retire_tag = '0;
    retire_data = '0; srca_reg = '0; srcb_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on several registers
    step("R1", 0,0,0, 0,0,0,0, 0, 3, 5);
    step("R1", 0,0,0, 0,0,0,0, 0, 7, 1);
    // R3: claim r3 with tag 5, same-cycle lookup sees old state
    step("R3", 1,3,5, 0,0,0,0, 0, 3, 3);
    step("R3", 0,0,0, 0,0,0,0, 0, 3, 2);
    // R5: rename r3 to tag 6, then retire stale tag 5
    step("R3", 1,3,6, 0,0,0,0, 0, 3, 4);
    step("R5", 0,0,0, 1,3,5,16'hAAAA, 0, 3, 1);
    step("R5", 0,0,0, 0,0,0,0, 0, 3, 3);
    // R9: retire matching tag 6, bypassed in same cycle
    step("R9", 0,0,0, 1,3,6,16'h1234, 0, 3, 2);
    step("R4", 0,0,0, 0,0,0,0, 0, 3, 3);
    // R9: retire a non-pending register, bypass
    step("R9", 0,0,0, 1,2,1,16'h0BEE, 0, 2, 3);
    step("R4", 0,0,0, 0,0,0,0, 0, 2, 2);
    // R6: r4 pending on 2, retire 2 and claim 3 same cycle
    step("R3", 1,4,2, 0,0,0,0, 0, 4, 4);
    step("R6", 1,4,3, 1,4,2,16'h4444, 0, 4, 0);
    step("R6", 0,0,0, 0,0,0,0, 0, 4, 4);
    // R8: register 0 ignores claims and retirement
    step("R8", 1,0,1, 0,0,0,0, 0, 0, 0);
    step("R8", 0,0,0, 1,0,1,16'h0055, 0, 0, 0);
    step("R8", 0,0,0, 0,0,0,0, 0, 0, 0);
    // R7: flush with concurrent claim and retirement
    step("R3", 1,5,4, 0,0,0,0, 0, 5, 4);
    step("R3", 1,6,7, 0,0,0,0, 0, 6, 5);
    step("R7", 1,7,1, 1,6,2,16'h0077, 1, 6, 7);
    step("R7", 0,0,0, 0,0,0,0, 0, 7, 6);
    step("R7", 0,0,0, 0,0,0,0, 0, 5, 4);

    // random traffic, auto-labelled per lookup
    for (int n = 0; n < 4000; n++) begin
      int ar, rr, rt;
      ar = $urandom_range(0, NREGS-1);
      rr = $urandom_range(0, NREGS-1);
      rt = $urandom_range(1, 7);
      if ($urandom_range(0, 1) == 1 && m_busy[rr]) rt = int'(m_tag[rr]);
      step("", $urandom_range(0, 1), ar, $urandom_range(1, 7),
           $urandom_range(0, 2) != 0, rr, rt, $urandom_range(0, 65535),
           $urandom_range(0, 31) == 0,
           $urandom_range(0, NREGS-1), $urandom_range(0, NREGS-1));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule